// File: doc/BRIEF.md
# Inbound Mailbox Queue Register Front-End

This block gives a host CPU a small set of 32-bit registers for collecting messages from the rest of the chip. An internal producer pushes words into an inbound queue through a dedicated push port. The host drains the queue by reading a data window, and each successful read removes the oldest word. The host can also look at the oldest word through a peek register without removing it. A status register reports whether the queue is full or empty. A config register holds the single writable interrupt enable and a read-only "data waiting" flag. The block also passes through the full and empty flags of a second, outbound queue that lives elsewhere, as a read-only word.

The bus is a single-cycle request port: valid, write, address, byte enables and write data. Only whole-word requests, with all four byte enables set, are acted on. Read data comes back one cycle after the request, together with a valid strobe. The interrupt output is a level signal. It stays high while data is waiting and the enable is set.

Top module: `mbox_regs`

## Requirements
- R1: Status word (offset 0x98) has bit 31 = 1 when the inbound queue holds DEPTH entries, bit 30 = 1 when it holds none, and all other bits 0; both flags follow every push and pop.
- R2: A read at any of offsets 0x80, 0x84, 0x88, 0x8C returns the oldest entry and removes it; entries leave in the order they were pushed.
- R3: A data-window read while the queue is empty returns 32'hFFFF_FFFF and leaves the queue unchanged.
- R4: A read at offset 0x90 returns the oldest entry without removing it; when the queue is empty it returns 32'hFFFF_FFFF.
- R5: A write to config (offset 0x9C) changes only bit 0 (interrupt enable). Config bit 4 reads 1 exactly when the queue is not empty. Every other config bit reads 0.
- R6: The irq output is high exactly when config bit 0 and config bit 4 are both 1.
- R7: A read at offset 0xB8 returns the outbound queue status: bit 31 = ob_full, bit 30 = ob_empty, other bits 0.
- R8: Only bus_addr[7:0] is decoded. A request whose byte enables are not all ones is ignored: it returns no rd_valid and has no effect.
- R9: After reset the queue is empty, config is 0, irq is 0, and the peek register returns 32'hFFFF_FFFF.
- R10: push_ready is low while the queue is full, and a push offered then is dropped.
- R11: A read at an unmapped offset returns 0 and has no side effect. Writes to unmapped or read-only offsets are ignored.
- R12: For every accepted read, rd_valid is high and rd_data holds the result in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [7:0] are decoded |
| bus_be | input | 4 | Byte enables; must be 4'hF to be acted on |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data strobe, one cycle after a read request |
| rd_data | output | 32 | Read data |
| push_valid | input | 1 | Offer a word to the inbound queue |
| push_data | input | 32 | Word to push |
| push_ready | output | 1 | Queue has room |
| ob_full | input | 1 | Outbound queue full flag |
| ob_empty | input | 1 | Outbound queue empty flag |
| irq | output | 1 | Data-available interrupt, level |

## Verification
A read request presented at one clock edge has its result registered at that edge, so the bench expects rd_data one cycle later and compares it at the following falling edge. A push and a config write take effect at the edge where they are presented. The irq, push_ready and status values that depend on them are checked from the next falling edge on. The read driver places each expected word in a scoreboard queue when it issues the request. A monitor takes the word off that queue when rd_valid appears, so a missing or extra strobe shows up as a mismatch.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] EMPTY_MARK = 32'hFFFF_FFFF;

    localparam logic [7:0] OFS_PEEK   = 8'h90;
    localparam logic [7:0] OFS_STATUS = 8'h98;
    localparam logic [7:0] OFS_CONFIG = 8'h9C;
    localparam logic [7:0] OFS_OBSTAT = 8'hB8;

    localparam int unsigned BIT_FULL  = 31;
    localparam int unsigned BIT_EMPTY = 30;
    localparam int unsigned BIT_IEN   = 0;
    localparam int unsigned BIT_PEND  = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POP,
        SEL_PEEK,
        SEL_STATUS,
        SEL_CONFIG,
        SEL_OBSTAT
    } reg_sel_e;
endpackage

// File: rtl/mbox_shift_queue.sv
module mbox_shift_queue
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_data_i,
    output logic [WORD_W-1:0] head_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              full_o,
    output logic              empty_o
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] slot;
        logic [CNT_W-1:0]             cnt;
    } q_t;

    q_t q_q, q_d;
    logic             do_pop, do_push;
    logic [CNT_W-1:0] base;

    always_comb begin
        q_d     = q_q;
        do_pop  = pop_i && (q_q.cnt != '0);
        do_push = push_i && (q_q.cnt != CNT_W'(DEPTH));
        if (do_pop) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                q_d.slot[i] = q_q.slot[i+1];
            end
            q_d.slot[DEPTH-1] = EMPTY_MARK;
        end
        base = q_q.cnt - CNT_W'(do_pop);
        if (do_push) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (CNT_W'(i) == base) begin
                    q_d.slot[i] = push_data_i;
                end
            end
        end
        q_d.cnt = base + CNT_W'(do_push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q.cnt <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                q_q.slot[i] <= EMPTY_MARK;
            end
        end else begin
            q_q <= q_d;
        end
    end

    assign head_o  = q_q.slot[0];
    assign cnt_o   = q_q.cnt;
    assign full_o  = (q_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (q_q.cnt == '0);
endmodule

// File: rtl/mbox_addr_decode.sv
module mbox_addr_decode
    import mbox_pkg::*;
(
    input  logic [7:0] ofs_i,
    output reg_sel_e   sel_o
);
    always_comb begin
        sel_o = SEL_NONE;
        if (ofs_i[1:0] == 2'b00) begin
            if (ofs_i[7:4] == 4'h8) begin
                sel_o = SEL_POP;
            end else begin
                unique case (ofs_i)
                    OFS_PEEK:   sel_o = SEL_PEEK;
                    OFS_STATUS: sel_o = SEL_STATUS;
                    OFS_CONFIG: sel_o = SEL_CONFIG;
                    OFS_OBSTAT: sel_o = SEL_OBSTAT;
                    default:    sel_o = SEL_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              push_valid,
    input  logic [31:0]       push_data,
    output logic              push_ready,
    input  logic              ob_full,
    input  logic              ob_empty,
    output logic              irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic        ien;
        logic        rvalid;
        logic [31:0] rdata;
    } st_t;

    st_t st_q, st_d;

    reg_sel_e         sel;
    logic             whole, rd_req, wr_req, pop_req;
    logic [31:0]      head;
    logic [CNT_W-1:0] q_cnt;
    logic             q_full, q_empty;
    logic             ien_q;

    mbox_addr_decode u_dec (
        .ofs_i (bus_addr[7:0]),
        .sel_o (sel)
    );

    mbox_shift_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (pop_req),
        .push_i      (push_valid),
        .push_data_i (push_data),
        .head_o      (head),
        .cnt_o       (q_cnt),
        .full_o      (q_full),
        .empty_o     (q_empty)
    );

    assign whole   = bus_valid && (bus_be == 4'hF);
    assign rd_req  = whole && !bus_write;
    assign wr_req  = whole && bus_write;
    assign pop_req = rd_req && (sel == SEL_POP);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_req;
        if (rd_req) begin
            st_d.rdata = '0;
            unique case (sel)
                SEL_POP:    st_d.rdata = q_empty ? EMPTY_MARK : head;
                SEL_PEEK:   st_d.rdata = head;
                SEL_STATUS: begin
                    st_d.rdata[BIT_FULL]  = q_full;
                    st_d.rdata[BIT_EMPTY] = q_empty;
                end
                SEL_CONFIG: begin
                    st_d.rdata[BIT_IEN]  = st_q.ien;
                    st_d.rdata[BIT_PEND] = !q_empty;
                end
                SEL_OBSTAT: begin
                    st_d.rdata[BIT_FULL]  = ob_full;
                    st_d.rdata[BIT_EMPTY] = ob_empty;
                end
                default:    st_d.rdata = '0;
            endcase
        end
        if (wr_req && (sel == SEL_CONFIG)) begin
            st_d.ien = bus_wdata[BIT_IEN];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_q      = st_q.ien;
    assign rd_valid   = st_q.rvalid;
    assign rd_data    = st_q.rdata;
    assign push_ready = !q_full;
    assign irq        = st_q.ien && !q_empty;
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic              push_valid,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              irq,
    input logic              ien,
    input logic [CNT_W-1:0]  cnt
);
    logic rd_any, rd_pop, rd_peek;
    assign rd_any  = bus_valid && !bus_write && (bus_be == 4'hF);
    assign rd_pop  = rd_any && (bus_addr[7:4] == 4'h8) && (bus_addr[1:0] == 2'b00);
    assign rd_peek = rd_any && (bus_addr[7:0] == 8'h90);

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_pop_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && cnt != '0 && !push_valid) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_empty_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && cnt == '0 && !push_valid) |=> (rd_data == 32'hFFFF_FFFF && cnt == '0));

    p_peek_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_peek && !push_valid) |=> (cnt == $past(cnt)));

    p_irq_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && cnt != '0));

    p_partial_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_be != 4'hF) |=> !rd_valid);

    p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> rd_valid);
endmodule

bind mbox_regs mbox_regs_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .push_valid (push_valid),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .irq        (irq),
    .ien        (ien_q),
    .cnt        (q_cnt)
);

// File: tb/tb_mbox_regs.sv
module tb_mbox_regs;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0]        bus_be = 4'hF;
    logic [31:0]       bus_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              push_valid = 1'b0;
    logic [31:0]       push_data = '0;
    logic              push_ready;
    logic              ob_full = 1'b0, ob_empty = 1'b1;
    logic              irq;

    mbox_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model[$];
    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare each returned word with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12 unexpected rd_valid", rd_data, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rd_data === e.val, e.tag, rd_data, e.val);
            end
        end
    end

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'hF;
        sb.push_back('{exp, tag});
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_be = 4'hF;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        push_valid = 1'b1; push_data = d;
        if (model.size() < DEPTH) model.push_back(d);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    function automatic logic [31:0] stat_exp();
        return {model.size() == DEPTH, model.size() == 0, 30'b0};
    endfunction

    task automatic pop_exp(input logic [ADDR_W-1:0] a, input string tag);
        logic [31:0] v;
        v = (model.size() == 0) ? 32'hFFFF_FFFF : model.pop_front();
        rd(a, v, tag);
    endtask

    bit done = 1'b0;
    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0, "R9 irq after reset", {31'b0, irq}, 32'h0);
        check(push_ready == 1'b1, "R10 push_ready after reset", {31'b0, push_ready}, 32'h1);
        rd(12'h098, 32'h4000_0000, "R9 R1 status after reset");
        rd(12'h09C, 32'h0, "R9 config after reset");
        rd(12'h090, 32'hFFFF_FFFF, "R9 R4 peek after reset");
        rd(12'h080, 32'hFFFF_FFFF, "R3 empty pop marker");
        rd(12'h098, 32'h4000_0000, "R3 still empty");

        wr(12'h09C, 32'hFFFF_FFFF, 4'hF);
        rd(12'h09C, 32'h1, "R5 only enable writable");
        check(irq == 1'b0, "R6 irq low when empty", {31'b0, irq}, 32'h0);

        push(32'hA000_0001); push(32'hA000_0002); push(32'hA000_0003);
        @(negedge clk);
        check(irq == 1'b1, "R6 irq with data and enable", {31'b0, irq}, 32'h1);
        rd(12'h09C, 32'h11, "R5 pending bit set");
        rd(12'h098, stat_exp(), "R1 status partial");
        rd(12'h090, model[0], "R4 peek head");
        rd(12'h090, model[0], "R4 peek again no pop");
        pop_exp(12'h084, "R2 pop via 0x84");
        pop_exp(12'h088, "R2 pop via 0x88");
        pop_exp(12'hF8C, "R8 upper address bits ignored");
        rd(12'h098, stat_exp(), "R1 empty after drain");
        @(negedge clk);
        check(irq == 1'b0, "R6 irq falls after drain", {31'b0, irq}, 32'h0);

        push(32'hB000_0000);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h080; bus_be = 4'h3;
        @(negedge clk);
        bus_valid = 1'b0; bus_be = 4'hF;
        check(rd_valid == 1'b0, "R8 partial read no strobe", {31'b0, rd_valid}, 32'h0);
        wr(12'h09C, 32'h0, 4'h1);
        rd(12'h09C, 32'h11, "R8 partial write ignored");
        rd(12'h090, model[0], "R8 partial read did not pop");
        pop_exp(12'h080, "R2 pop single");

        for (int i = 0; i < DEPTH + 1; i++) push(32'hC000_0000 + i);
        @(negedge clk);
        check(push_ready == 1'b0, "R10 push_ready low when full", {31'b0, push_ready}, 32'h0);
        rd(12'h098, 32'h8000_0000, "R1 full flag");
        wr(12'h098, 32'h0, 4'hF);
        wr(12'h080, 32'h0, 4'hF);
        wr(12'h040, 32'h0, 4'hF);
        rd(12'h098, 32'h8000_0000, "R11 writes to read-only ignored");
        rd(12'h040, 32'h0, "R11 unmapped read zero");
        rd(12'h098, 32'h8000_0000, "R11 unmapped read no effect");
        wr(12'h09C, 32'h0, 4'hF);
        @(negedge clk);
        check(irq == 1'b0, "R6 irq low with enable clear", {31'b0, irq}, 32'h0);
        for (int i = 0; i < DEPTH; i++) pop_exp(12'h080, "R2 R10 drain order, overflow dropped");
        rd(12'h080, 32'hFFFF_FFFF, "R3 marker after drain");
        rd(12'h090, 32'hFFFF_FFFF, "R4 peek marker when empty");

        ob_full = 1'b1; ob_empty = 1'b0;
        rd(12'h0B8, 32'h8000_0000, "R7 outbound full");
        ob_full = 1'b0; ob_empty = 1'b1;
        rd(12'h0B8, 32'h4000_0000, "R7 outbound empty");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R12 all reads answered", sb.size(), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule